// File: doc/BRIEF.md
# Dual-Gain Range-Bin Merger

This block merges two simultaneously sampled ADC streams into one wider word. One stream comes from a high-gain path that resolves weak returns. The other comes from a low-gain path that stays in range on strong returns. Samples are grouped into range bins of programmable length. Each high-gain sample's magnitude is scanned as the bin fills. When the bin closes, one channel is chosen for the whole bin. A bin switches to the low-gain channel if any of its high-gain magnitudes is strictly above a programmable threshold; otherwise it stays on the high-gain channel.

Both channels are written into a two-bank buffer, so a finished bin can be replayed with its decision applied while the next bin fills the other bank. Each replayed sample is sign-extended to a 20-bit two's-complement word. A low-gain sample is also shifted left by a fixed amount that compensates the gain offset between the paths, so both channels share one scale. A per-word flag tells downstream logic which channel produced the word.

Top module: `dual_gain_merger`

## Requirements
- R1: While reset is held low at a clock edge and after that edge, out_valid, out_word and out_lo_sel are all zero.
- R2: An accepted sample with bin_start high opens a bin when none is open. The bin holds exactly the number of accepted samples given by bin_len, sampled in that cycle. Any length from 1 up to DEPTH (512) is accepted, and the last sample of a bin may carry the deciding value.
- R3: The words of a bin come out on consecutive cycles, in arrival order. Word k appears after the clock edge that falls 3+k edges after the edge that accepted the bin's last sample. With gap-free input this is a latency of bin_len+2 cycles.
- R4: A sample's magnitude is the absolute value of its 14-bit two's-complement code. The code -8192 counts as magnitude 8192, so it exceeds every threshold, including 8191.
- R5: When no high-gain magnitude in a bin is greater than hot_thresh, every word of the bin comes from hi_smp and carries out_lo_sel = 0.
- R6: When at least one high-gain magnitude in a bin is strictly greater than hot_thresh, every word of the bin comes from lo_smp and carries out_lo_sel = 1. A magnitude equal to hot_thresh does not switch the bin.
- R7: A high-gain word is the 14-bit sample sign-extended to 20 bits with no shift.
- R8: A low-gain word is the 14-bit sample sign-extended to 20 bits and then shifted left by SHIFT (default 4). The SHIFT low bits are zero.
- R9: Samples offered with in_valid high while no bin is open and bin_start low are dropped and produce no output. A bin_start pulse inside an open bin is ignored, and that sample counts as an ordinary member of the open bin.
- R10: Cycles with in_valid low inside an open bin neither add a sample nor end the bin. The replay still starts as R3 states, from the edge that accepted the last sample.
- R11: In every cycle where out_valid is low, out_word and out_lo_sel are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample pair is offered this cycle |
| bin_start | input | 1 | This sample is the first of a new range bin |
| hi_smp | input | 14 | High-gain channel sample, two's complement |
| lo_smp | input | 14 | Low-gain channel sample, two's complement |
| bin_len | input | 10 | Bin length in samples (1 to DEPTH), taken when a bin opens |
| hot_thresh | input | 13 | Unsigned magnitude threshold for the high-gain channel |
| out_valid | output | 1 | A merged word is present |
| out_word | output | 20 | Merged word on the low-gain-referenced 20-bit scale |
| out_lo_sel | output | 1 | 1 when the word came from the low-gain channel |

## Verification
The assertions assume that bin_len lies between 1 and DEPTH whenever a bin opens. They also assume that a bin never completes while the replay of the previous bin still has more than its final read pending. That holds when consecutive bins share one length, or when enough idle cycles pass before a shorter bin follows. The bench changes bin_len and hot_thresh only after the buffer has drained, and it keeps back-to-back bins at one length. Within those limits it covers gaps in in_valid, stray bin_start pulses, bins of length 1 and of full depth, and threshold values placed exactly on and just past the compare point.

// File: rtl/dgm_pkg.sv
// Package dgm_pkg
// Shared widths, sample types and small helpers for the dual-gain merger.
// Assumes both ADC channels deliver samples of the same width.
package dgm_pkg;
    parameter int SMP_W = 14;              // width of each ADC sample
    parameter int OUT_W = 20;              // width of the merged word
    localparam int THR_W = SMP_W - 1;      // threshold covers magnitudes below full scale

    typedef logic signed [SMP_W-1:0] smp_t;

    typedef struct packed {
        smp_t hi;
        smp_t lo;
    } pair_t;

    // Absolute value as an unsigned code; the most negative code maps to 2**(SMP_W-1).
    function automatic logic [SMP_W-1:0] smp_mag(input smp_t s);
        logic [SMP_W-1:0] inv;
        inv = ~s;
        return s[SMP_W-1] ? (inv + {{(SMP_W-1){1'b0}}, 1'b1}) : s;
    endfunction

    // Sign-extend one sample to the merged width.
    function automatic logic [OUT_W-1:0] smp_ext(input smp_t s);
        return {{(OUT_W-SMP_W){s[SMP_W-1]}}, s};
    endfunction
endpackage

// File: rtl/dgm_peak_track.sv
// Module dgm_peak_track
// Follows the largest high-gain magnitude seen in the current bin and reports
// whether that running peak, including the sample offered this cycle, is
// strictly above the threshold. The `hot` output is combinational so that the
// cycle which accepts a bin's last sample also sees that bin's decision.
// Assumes thresh is held steady while a bin is open.
module dgm_peak_track
    import dgm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             first,
    input  smp_t             smp,
    input  logic [THR_W-1:0] thresh,
    output logic             hot
);
    logic [SMP_W-1:0] peak_q;
    logic [SMP_W-1:0] mag;
    logic [SMP_W-1:0] peak_next;

    // Running maximum; the first sample of a bin replaces the old peak.
    always_comb begin
        mag = smp_mag(smp);
        if (first || mag > peak_q)
            peak_next = mag;
        else
            peak_next = peak_q;
    end

    assign hot = peak_next > {1'b0, thresh};

    // Hold the peak between accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)
            peak_q <= '0;
        else if (smp_valid)
            peak_q <= peak_next;
    end

    // R4
    peak_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !first) |=> (peak_q >= $past(peak_q)));
endmodule

// File: rtl/dgm_pingpong.sv
// Module dgm_pingpong
// Two-bank sample store for both channels. One bank is filled by the bin
// being collected while the other is replayed. The read port is synchronous,
// so data appear one cycle after the read request.
// Assumes the controller never writes the bank that is being read.
module dgm_pingpong
    import dgm_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  pair_t         wr_data,
    input  logic          rd_en,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output pair_t         rd_data
);
    localparam int ENTRIES = 2 * DEPTH;

    pair_t mem [ENTRIES];

    // Store the incoming pair in the selected bank.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[{wr_bank, wr_addr}] <= wr_data;
    end

    // Registered read of the bank being replayed.
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_data <= mem[{rd_bank, rd_addr}];
    end

    // R3
    bank_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |-> (wr_bank != rd_bank));
endmodule

// File: rtl/dgm_scaler.sv
// Module dgm_scaler
// Two register stages that turn a replayed pair into a merged word. The first
// stage picks the channel named by the bin decision and sign-extends it. The
// second stage applies the gain-compensating left shift to low-gain words.
// Outputs are forced to zero on cycles without a valid word.
module dgm_scaler
    import dgm_pkg::*;
#(
    parameter int SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_lo_sel,
    input  pair_t            in_pair,
    output logic             out_valid,
    output logic             out_lo_sel,
    output logic [OUT_W-1:0] out_word
);
    logic             a_valid;
    logic             a_sel;
    logic [OUT_W-1:0] a_word;
    logic [OUT_W-1:0] a_scaled;

    // Stage A: choose the channel and widen it.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            a_valid <= 1'b0;
            a_sel   <= 1'b0;
            a_word  <= '0;
        end else begin
            a_valid <= 1'b1;
            a_sel   <= in_lo_sel;
            a_word  <= in_lo_sel ? smp_ext(in_pair.lo) : smp_ext(in_pair.hi);
        end
    end

    generate
        if (SHIFT > 0) begin : g_shift
            assign a_scaled = {a_word[OUT_W-1-SHIFT:0], {SHIFT{1'b0}}};

            // R8
            lo_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_lo_sel) |-> (out_word[SHIFT-1:0] == '0));
        end else begin : g_noshift
            assign a_scaled = a_word;
        end
    endgenerate

    // Stage B: scale low-gain words onto the common grid and drive the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !a_valid) begin
            out_valid  <= 1'b0;
            out_lo_sel <= 1'b0;
            out_word   <= '0;
        end else begin
            out_valid  <= 1'b1;
            out_lo_sel <= a_sel;
            out_word   <= a_sel ? a_scaled : a_word;
        end
    end

    // R7
    hi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_lo_sel) |->
            ((&out_word[OUT_W-1:SMP_W-1]) || !(|out_word[OUT_W-1:SMP_W-1])));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_word == '0 && !out_lo_sel));
endmodule

// File: rtl/dual_gain_merger.sv
// Module dual_gain_merger
// Collects range bins from two simultaneously sampled channels, decides per
// bin which channel to use from the high-gain peak, and replays the bin from
// a two-bank buffer as 20-bit words scaled to the low-gain reference.
// Assumes bin_len is in 1..DEPTH when a bin opens and that a bin does not
// complete while the previous replay still has reads outstanding.
module dual_gain_merger
    import dgm_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int SHIFT = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             bin_start,
    input  logic [SMP_W-1:0] hi_smp,
    input  logic [SMP_W-1:0] lo_smp,
    input  logic [LEN_W-1:0] bin_len,
    input  logic [THR_W-1:0] hot_thresh,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_word,
    output logic             out_lo_sel
);
    // Collection side state.
    logic             open_q;
    logic [LEN_W-1:0] wcnt_q;
    logic [LEN_W-1:0] cur_len_q;
    logic             wbank_q;

    logic             start;
    logic             wr_en;
    logic             bin_done;
    logic             bin_hot;
    logic [LEN_W-1:0] pos;
    logic [LEN_W-1:0] len_now;
    logic             bank_now;

    // Replay side state.
    logic             rd_active;
    logic [LEN_W-1:0] rd_cnt;
    logic [LEN_W-1:0] rd_len;
    logic             rd_bank;
    logic             rd_sel;
    logic             rd_last;
    logic             v1_q;
    logic             sel1_q;
    pair_t            rd_pair;
    pair_t            wr_pair;

    assign start    = in_valid && bin_start && !open_q;
    assign wr_en    = in_valid && (open_q || bin_start);
    assign pos      = start ? '0 : wcnt_q;
    assign len_now  = start ? bin_len : cur_len_q;
    assign bank_now = start ? ~wbank_q : wbank_q;
    assign bin_done = wr_en && (pos == len_now - 1'b1);
    assign rd_last  = rd_active && (rd_cnt == rd_len - 1'b1);
    assign wr_pair  = '{hi: hi_smp, lo: lo_smp};

    // Track the open bin, its fill position, length and bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q    <= 1'b0;
            wcnt_q    <= '0;
            cur_len_q <= '0;
            wbank_q   <= 1'b0;
        end else if (wr_en) begin
            open_q <= !bin_done;
            wcnt_q <= pos + 1'b1;
            if (start) begin
                cur_len_q <= bin_len;
                wbank_q   <= bank_now;
            end
        end
    end

    // Launch a replay when a bin closes and step through it one word per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            rd_cnt    <= '0;
            rd_len    <= '0;
            rd_bank   <= 1'b0;
            rd_sel    <= 1'b0;
        end else if (bin_done) begin
            rd_active <= 1'b1;
            rd_cnt    <= '0;
            rd_len    <= len_now;
            rd_bank   <= bank_now;
            rd_sel    <= bin_hot;
        end else if (rd_active) begin
            rd_cnt <= rd_cnt + 1'b1;
            if (rd_last)
                rd_active <= 1'b0;
        end
    end

    // Align the valid and decision with the registered memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q   <= 1'b0;
            sel1_q <= 1'b0;
        end else begin
            v1_q   <= rd_active;
            sel1_q <= rd_sel;
        end
    end

    dgm_peak_track u_peak (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (wr_en),
        .first     (start),
        .smp       (hi_smp),
        .thresh    (hot_thresh),
        .hot       (bin_hot)
    );

    dgm_pingpong #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (bank_now),
        .wr_addr (pos[AW-1:0]),
        .wr_data (wr_pair),
        .rd_en   (rd_active),
        .rd_bank (rd_bank),
        .rd_addr (rd_cnt[AW-1:0]),
        .rd_data (rd_pair)
    );

    dgm_scaler #(.SHIFT(SHIFT)) u_scale (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (v1_q),
        .in_lo_sel  (sel1_q),
        .in_pair    (rd_pair),
        .out_valid  (out_valid),
        .out_lo_sel (out_lo_sel),
        .out_word   (out_word)
    );

    // R2
    bin_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (bin_len != '0 && bin_len <= LEN_W'(DEPTH)));

    // R2
    fill_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (wcnt_q < cur_len_q));

    // R3
    drain_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bin_done |-> (!rd_active || rd_last));
endmodule

// File: tb/dual_gain_merger_bench.sv
module dual_gain_merger_bench;
    localparam int DEPTH = 512;
    localparam int SHIFT = 4;
    localparam int LEN_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             bin_start = 1'b0;
    logic [13:0]      hi_smp = '0;
    logic [13:0]      lo_smp = '0;
    logic [LEN_W-1:0] bin_len = 10'd8;
    logic [12:0]      hot_thresh = 13'd1000;
    logic             out_valid;
    logic [19:0]      out_word;
    logic             out_lo_sel;

    always #2 clk = ~clk;

    dual_gain_merger #(.DEPTH(DEPTH), .SHIFT(SHIFT)) u_dual_gain_merger (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .bin_start  (bin_start),
        .hi_smp     (hi_smp),
        .lo_smp     (lo_smp),
        .bin_len    (bin_len),
        .hot_thresh (hot_thresh),
        .out_valid  (out_valid),
        .out_word   (out_word),
        .out_lo_sel (out_lo_sel)
    );

    int    n_run = 0;
    int    n_fail = 0;
    int    edge_n = 0;
    bit    finished = 0;
    string bin_tag = "R3";
    string idle_tag = "R1";

    // Reference model state
    bit          m_open = 0;
    int          m_len = 0;
    int          m_hi[$];
    int          m_lo[$];
    int          e_cyc[$];
    logic [19:0] e_word[$];
    bit          e_flag[$];
    string       e_tag[$];

    function automatic int smag(int v);
        return (v < 0) ? -v : v;
    endfunction

    // Behavioural model of the inputs that the next edge (number e) accepts.
    task automatic model_step(int e);
        bit take;
        bit hot;
        int val;
        if (!rst_n) return;
        take = 0;
        if (!m_open) begin
            if (in_valid && bin_start) begin
                m_open = 1;
                m_len  = int'(bin_len);
                m_hi.delete();
                m_lo.delete();
                take = 1;
            end
        end else if (in_valid) begin
            take = 1;
        end
        if (!take) return;
        m_hi.push_back(int'($signed(hi_smp)));
        m_lo.push_back(int'($signed(lo_smp)));
        if (m_hi.size() == m_len) begin
            hot = 0;
            foreach (m_hi[i]) if (smag(m_hi[i]) > int'(hot_thresh)) hot = 1;
            foreach (m_hi[i]) begin
                val = hot ? m_lo[i] * (1 << SHIFT) : m_hi[i];
                e_cyc.push_back(e + 3 + i);
                e_word.push_back(20'(val));
                e_flag.push_back(hot);
                e_tag.push_back(bin_tag);
            end
            m_open = 0;
        end
    endtask

    task automatic check(int n);
        n_run++;
        if (e_cyc.size() > 0 && e_cyc[0] == n) begin
            if (out_valid !== 1'b1 || out_word !== e_word[0] || out_lo_sel !== e_flag[0]) begin
                n_fail++;
                $display("FAIL %s edge %0d: actual valid=%0b word=%h sel=%0b, expected valid=1 word=%h sel=%0b",
                         e_tag[0], n, out_valid, out_word, out_lo_sel, e_word[0], e_flag[0]);
            end
            void'(e_cyc.pop_front());
            void'(e_word.pop_front());
            void'(e_flag.pop_front());
            void'(e_tag.pop_front());
        end else if (out_valid !== 1'b0 || out_word !== '0 || out_lo_sel !== 1'b0) begin
            n_fail++;
            $display("FAIL %s edge %0d: actual valid=%0b word=%h sel=%0b, expected valid=0 word=00000 sel=0",
                     idle_tag, n, out_valid, out_word, out_lo_sel);
        end
    endtask

    task automatic tick();
        model_step(edge_n + 1);
        @(posedge clk);
        edge_n++;
        @(negedge clk);
        check(edge_n);
    endtask

    task automatic send(bit v, bit bs, int h, int l);
        in_valid  = v;
        bin_start = bs;
        hi_smp    = 14'(h);
        lo_smp    = 14'(l);
        tick();
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) send(0, 0, 0, 0);
    endtask

    // One gap-free bin with alternating signs and an optional spike.
    task automatic bin_of(int len, int base, int step, int spike_pos, int spike_val);
        int h;
        for (int i = 0; i < len; i++) begin
            h = ((i % 2) == 1) ? -(base + i * step) : (base + i * step);
            if (i == spike_pos) h = spike_val;
            send(1, i == 0, h, i * 37 - 100);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        idle_tag = "R1";
        rst_n = 0;
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1;
        idle_tag = "R11";
        idle(2);

        // R3/R5/R7: quiet bin stays on high gain; R6/R8: spike switches the next bin
        bin_len = 10'd8; hot_thresh = 13'd1000;
        bin_tag = "R3/R5/R7"; bin_of(8, 100, 50, -1, 0);
        bin_tag = "R6/R8";    bin_of(8, 100, 50, 3, 1001);
        bin_tag = "R6";       bin_of(8, 100, 50, 5, -1000);
        idle(12);

        // R4: most negative code exceeds the top threshold; 8191 does not
        bin_len = 10'd4; hot_thresh = 13'd8191;
        bin_tag = "R4"; bin_of(4, 10, 1, 2, -8192);
        bin_tag = "R4"; bin_of(4, 10, 1, 1, 8191);
        idle(8);

        // R10: gaps inside a bin
        bin_len = 10'd6; hot_thresh = 13'd500;
        bin_tag = "R10";
        for (int i = 0; i < 6; i++) begin
            send(1, i == 0, (i == 4) ? -600 : 20 * i, 300 - 90 * i);
            if (i < 5) idle(1 + (i % 3));
        end
        idle(12);

        // R9: stray samples with no open bin, and a bin_start inside an open bin
        idle_tag = "R9";
        for (int i = 0; i < 4; i++) send(1, 0, 7000, 400 + i);
        idle(4);
        bin_tag = "R9";
        for (int i = 0; i < 6; i++) send(1, (i == 0) || (i == 3), 40 * i - 90, 11 * i);
        idle(12);
        idle_tag = "R11";

        // R2: single-sample bins back to back
        bin_len = 10'd1; hot_thresh = 13'd200;
        bin_tag = "R2";
        for (int i = 0; i < 6; i++)
            send(1, 1, (i % 2 == 1) ? 201 - i : 150 + i, -50 * i);
        idle(6);

        // R2/R3: longer bins with pseudo-random data
        bin_len = 10'd40; hot_thresh = 13'd6000;
        bin_tag = "R2/R3";
        for (int b = 0; b < 3; b++)
            for (int i = 0; i < 40; i++)
                send(1, i == 0,
                     (b == 1) ? int'($urandom_range(0, 16383)) - 8192
                              : int'($urandom_range(0, 8000)) - 4000,
                     int'($urandom_range(0, 16383)) - 8192);
        idle(46);

        // R2: full-depth bin decided by its very last sample
        bin_len = 10'(DEPTH); hot_thresh = 13'd3000;
        bin_tag = "R2";
        for (int i = 0; i < DEPTH; i++)
            send(1, i == 0, (i == DEPTH - 1) ? -3001 : int'($urandom_range(0, 6000)) - 3000,
                 int'($urandom_range(0, 16383)) - 8192);
        idle(DEPTH + 6);

        // R3: every expected word was seen
        n_run++;
        if (e_cyc.size() != 0) begin
            n_fail++;
            $display("FAIL R3 pending words: actual %0d left, expected 0", e_cyc.size());
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R3 watchdog: actual run still busy, expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule